// File: doc/BRIEF.md
# Condition-Field Compare Unit

This unit compares a 64-bit operand with a second operand and writes the outcome into one 4-bit field of a 32-bit condition register. The second operand is either another 64-bit operand or a 16-bit immediate, extended by sign or by zeros. The register holds eight such fields. The comparison can be signed or unsigned, and it can cover the full 64 bits or only the low 32-bit words.

A fifth operation searches for a byte. It reports whether the lowest byte of the first operand matches any of the eight bytes of the second operand.

The caller presents the current condition register, the summary-overflow flag, the operation code, the target field index and the width bit. One clock later, the unit returns the condition register with only the addressed field replaced. Every other field passes through unchanged. The output is registered, so the result always appears one cycle after the inputs.

Top module: `crf_compare_unit`

## Requirements
- R1: A compare operation (codes 0 to 3) writes a field whose bit 3 means less-than, bit 2 means greater-than and bit 1 means equal, with exactly one of these three set. Bit 0 is a copy of `so_in`.
- R2: Field k occupies `cr_out` bits [31-4k : 28-4k], so field 0 is the top nibble and field 7 the bottom nibble. All fields other than the one selected by `field_sel` keep their `cr_in` values.
- R3: With `wide`=0, only bits [31:0] of the two operands are compared; the upper 32 bits have no effect. For example, 0xFFFFFFFFAAAAAAAA against 0x00000000AAAAAAAA gives equal (0x2).
- R4: With `wide`=1, all 64 bits are compared. For example, a signed compare of 0xFFFFFFFFAAAAAAAA against 0x00000000AAAAAAAA gives less-than, and swapping the operands gives greater-than.
- R5: Codes 0 (register) and 2 (immediate) compare as two's-complement signed values at the selected width.
- R6: Codes 1 (register) and 3 (immediate) compare as unsigned values. For example, 0 against 0xFFFF6DC1 with `so_in`=1 gives field 0x9.
- R7: Code 2 compares against `imm` sign-extended to 64 bits, and code 3 against `imm` zero-extended; `op_b` is ignored for both. For example, code 3 with 0x301FC7A7 against 31132 and `so_in`=1 gives 0x5.
- R8: Code 4 writes 0x4 when `op_a[7:0]` equals any byte of `op_b`, and 0x0 otherwise. Neither `so_in` nor `wide` affects it.
- R9: Codes 5, 6 and 7 write no field: `cr_out` equals `cr_in`.
- R10: `cr_out` shows the result for the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears it to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand (register forms and byte search) |
| imm | input | 16 | Immediate for codes 2 and 3 |
| op | input | 3 | Operation code |
| field_sel | input | 3 | Index of the field to write |
| wide | input | 1 | 1: 64-bit compare, 0: 32-bit compare |
| cr_in | input | 32 | Current condition register |
| so_in | input | 1 | Summary-overflow flag copied into compare results |
| cr_out | output | 32 | Updated condition register (registered) |

## Verification
The assertions assume that every input is a known value at each rising edge outside reset, and that `op` may take any 3-bit value, including the reserved codes. The checker keeps its own copy of the previous cycle's selector, operation and register. It relies only on the field shape, the pass-through of untouched fields and equality cases, which hold for all operand values. The stimulus drives every input at the falling edge, so each value is settled for the following edge. It mixes directed boundary values (sign-bit words, wide and narrow splits, a byte match in every lane) with random operands over all eight operation codes.

// File: rtl/crf_cmp_pkg.sv
`timescale 1ns/1ps
package crf_cmp_pkg;
  localparam int FIELD_W = 4;

  typedef enum logic [2:0] {
    OP_SCMP  = 3'd0,
    OP_UCMP  = 3'd1,
    OP_SCMPI = 3'd2,
    OP_UCMPI = 3'd3,
    OP_BYTEQ = 3'd4
  } cmp_op_e;

  typedef struct packed {
    logic lt;
    logic gt;
    logic eq;
    logic so;
  } crf_t;
endpackage

// File: rtl/crf_operand_sel.sv
`timescale 1ns/1ps
module crf_operand_sel #(
  parameter int DATA_W = 64,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  input  logic              imm_signed,
  output logic [DATA_W-1:0] opnd
);
  localparam int PAD_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  assign imm_ext = {{PAD_W{imm_signed & imm[IMM_W-1]}}, imm};
  assign opnd    = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/crf_magnitude.sv
`timescale 1ns/1ps
module crf_magnitude #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              wide,
  input  logic              is_signed,
  output logic              lt,
  output logic              gt,
  output logic              eq
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W:0] ext_a;
  logic [DATA_W:0] ext_b;

  // One extra bit turns both signed and unsigned forms into a signed compare.
  always_comb begin
    if (wide) begin
      ext_a = {is_signed & a[DATA_W-1], a};
      ext_b = {is_signed & b[DATA_W-1], b};
    end else begin
      ext_a = {{(HALF_W+1){is_signed & a[HALF_W-1]}}, a[HALF_W-1:0]};
      ext_b = {{(HALF_W+1){is_signed & b[HALF_W-1]}}, b[HALF_W-1:0]};
    end
  end

  assign lt = $signed(ext_a) < $signed(ext_b);
  assign gt = $signed(ext_a) > $signed(ext_b);
  assign eq = ext_a == ext_b;
endmodule

// File: rtl/crf_byte_search.sv
`timescale 1ns/1ps
module crf_byte_search #(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              hit
);
  localparam int NBYTES = DATA_W / 8;

  logic [NBYTES-1:0] lane_hit;

  for (genvar g = 0; g < NBYTES; g++) begin : g_lane
    assign lane_hit[g] = b[g*8 +: 8] == a[7:0];
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/crf_field_merge.sv
`timescale 1ns/1ps
module crf_field_merge #(
  parameter int NUM_FIELDS = 8,
  parameter int FIELD_W    = 4,
  localparam int CR_W      = NUM_FIELDS * FIELD_W,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic [CR_W-1:0]    cr_in,
  input  logic [SEL_W-1:0]   sel,
  input  logic               we,
  input  logic [FIELD_W-1:0] new_field,
  output logic [CR_W-1:0]    cr_next
);
  // Field 0 sits in the most significant nibble.
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_field
    localparam int LO = (NUM_FIELDS - 1 - f) * FIELD_W;
    assign cr_next[LO +: FIELD_W] =
      (we && sel == SEL_W'(f)) ? new_field : cr_in[LO +: FIELD_W];
  end
endmodule

// File: rtl/crf_compare_unit.sv
`timescale 1ns/1ps
module crf_compare_unit
  import crf_cmp_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int IMM_W      = 16,
  parameter int NUM_FIELDS = 8,
  localparam int CR_W      = NUM_FIELDS * FIELD_W,
  localparam int SEL_W     = $clog2(NUM_FIELDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic [2:0]        op,
  input  logic [SEL_W-1:0]  field_sel,
  input  logic              wide,
  input  logic [CR_W-1:0]   cr_in,
  input  logic              so_in,
  output logic [CR_W-1:0]   cr_out
);
  cmp_op_e           op_e;
  logic              use_imm;
  logic              is_signed;
  logic              is_byte;
  logic              we;
  logic [DATA_W-1:0] opnd;
  logic              lt, gt, eq;
  logic              hit;
  crf_t              new_field;
  logic [CR_W-1:0]   cr_next;

  assign op_e = cmp_op_e'(op);

  always_comb begin
    use_imm   = 1'b0;
    is_signed = 1'b0;
    is_byte   = 1'b0;
    we        = 1'b1;
    case (op_e)
      OP_SCMP:  is_signed = 1'b1;
      OP_UCMP:  ;
      OP_SCMPI: begin use_imm = 1'b1; is_signed = 1'b1; end
      OP_UCMPI: use_imm = 1'b1;
      OP_BYTEQ: is_byte = 1'b1;
      default:  we = 1'b0;
    endcase
  end

  crf_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .reg_b(op_b), .imm(imm), .use_imm(use_imm),
    .imm_signed(is_signed), .opnd(opnd)
  );

  crf_magnitude #(.DATA_W(DATA_W)) u_mag (
    .a(op_a), .b(opnd), .wide(wide), .is_signed(is_signed),
    .lt(lt), .gt(gt), .eq(eq)
  );

  crf_byte_search #(.DATA_W(DATA_W)) u_bsrch (
    .a(op_a), .b(op_b), .hit(hit)
  );

  always_comb begin
    if (is_byte) new_field = '{lt: 1'b0, gt: hit, eq: 1'b0, so: 1'b0};
    else         new_field = '{lt: lt, gt: gt, eq: eq, so: so_in};
  end

  crf_field_merge #(.NUM_FIELDS(NUM_FIELDS), .FIELD_W(FIELD_W)) u_merge (
    .cr_in(cr_in), .sel(field_sel), .we(we),
    .new_field(new_field), .cr_next(cr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) cr_out <= '0;
    else     cr_out <= cr_next;
  end
endmodule

// File: rtl/crf_compare_checker.sv
`timescale 1ns/1ps
module crf_compare_checker
  import crf_cmp_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int NUM_FIELDS = 8,
  localparam int CR_W      = NUM_FIELDS * FIELD_W,
  localparam int SEL_W     = $clog2(NUM_FIELDS),
  localparam int HALF_W    = DATA_W / 2
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [2:0]        op,
  input logic [SEL_W-1:0]  field_sel,
  input logic              wide,
  input logic [CR_W-1:0]   cr_in,
  input logic              so_in,
  input logic [CR_W-1:0]   cr_out
);
  logic               live_q;
  logic [SEL_W-1:0]   sel_q;
  logic [2:0]         op_q;
  logic               so_q, wide_q, lo_eq_q, full_eq_q;
  logic [CR_W-1:0]    crin_q;
  logic [FIELD_W-1:0] fld;
  logic               cmp_q, reg_cmp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q    <= 1'b0;
      sel_q     <= '0;
      op_q      <= '0;
      so_q      <= 1'b0;
      wide_q    <= 1'b0;
      lo_eq_q   <= 1'b0;
      full_eq_q <= 1'b0;
      crin_q    <= '0;
    end else begin
      live_q    <= 1'b1;
      sel_q     <= field_sel;
      op_q      <= op;
      so_q      <= so_in;
      wide_q    <= wide;
      lo_eq_q   <= op_a[HALF_W-1:0] == op_b[HALF_W-1:0];
      full_eq_q <= op_a == op_b;
      crin_q    <= cr_in;
    end
  end

  always_comb fld = cr_out[(NUM_FIELDS - 1 - sel_q) * FIELD_W +: FIELD_W];
  assign cmp_q     = op_q <= 3'd3;
  assign reg_cmp_q = op_q == 3'd0 || op_q == 3'd1;

  p_one_flag_r1: assert property (@(posedge clk) disable iff (rst)
    (live_q && cmp_q) |-> $countones(fld[3:1]) == 1);

  p_so_copy_r1: assert property (@(posedge clk) disable iff (rst)
    (live_q && cmp_q) |-> fld[0] == so_q);

  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_keep
    localparam int LO = (NUM_FIELDS - 1 - f) * FIELD_W;
    p_fields_kept_r2: assert property (@(posedge clk) disable iff (rst)
      (live_q && sel_q != SEL_W'(f)) |-> cr_out[LO +: FIELD_W] == crin_q[LO +: FIELD_W]);
  end

  p_narrow_equal_r3: assert property (@(posedge clk) disable iff (rst)
    (live_q && reg_cmp_q && !wide_q && lo_eq_q) |-> fld[1]);

  p_wide_equal_r4: assert property (@(posedge clk) disable iff (rst)
    (live_q && reg_cmp_q && wide_q) |-> fld[1] == full_eq_q);

  p_byte_shape_r8: assert property (@(posedge clk) disable iff (rst)
    (live_q && op_q == 3'd4) |-> (fld[3] == 1'b0 && fld[1:0] == 2'b00));

  p_reserved_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (live_q && op_q > 3'd4) |-> cr_out == crin_q);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> cr_out == '0);
endmodule

bind crf_compare_unit crf_compare_checker #(
  .DATA_W(DATA_W), .NUM_FIELDS(NUM_FIELDS)
) u_chk (
  .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .op(op),
  .field_sel(field_sel), .wide(wide), .cr_in(cr_in), .so_in(so_in),
  .cr_out(cr_out)
);

// File: tb/crf_compare_unit_test.sv
`timescale 1ns/1ps
module crf_compare_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] op_a = '0, op_b = '0;
  logic [15:0] imm = '0;
  logic [2:0]  op = '0, field_sel = '0;
  logic        wide = 1'b0, so_in = 1'b0;
  logic [31:0] cr_in = '0;
  logic [31:0] cr_out;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } sb_item_t;
  sb_item_t sbq[$];

  always #5 clk = ~clk;

  crf_compare_unit uut (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .imm(imm), .op(op),
    .field_sel(field_sel), .wide(wide), .cr_in(cr_in), .so_in(so_in),
    .cr_out(cr_out)
  );

  function automatic logic [31:0] model(logic [63:0] a, logic [63:0] b,
      logic [15:0] im, logic [2:0] o, logic [2:0] s, logic w,
      logic [31:0] cr, logic so);
    logic [3:0]  f;
    logic [63:0] bb;
    logic        sgn, lt, gt;
    logic [31:0] r;
    longint      sa, sb;
    int          ia, ib;
    if (o > 3'd4) return cr;
    if (o == 3'd4) begin
      f = 4'h0;
      for (int i = 0; i < 8; i++) if (a[7:0] == b[i*8 +: 8]) f = 4'h4;
    end else begin
      if (o == 3'd2)      bb = {{48{im[15]}}, im};
      else if (o == 3'd3) bb = {48'h0, im};
      else                bb = b;
      sgn = (o == 3'd0) || (o == 3'd2);
      if (w && sgn) begin
        sa = a; sb = bb; lt = sa < sb; gt = sa > sb;
      end else if (w) begin
        lt = a < bb; gt = a > bb;
      end else if (sgn) begin
        ia = a[31:0]; ib = bb[31:0]; lt = ia < ib; gt = ia > ib;
      end else begin
        lt = a[31:0] < bb[31:0]; gt = a[31:0] > bb[31:0];
      end
      f = {lt, gt, !(lt || gt), so};
    end
    r = cr;
    r[31 - 4*s -: 4] = f;
    return r;
  endfunction

  task automatic drive(logic [63:0] a, logic [63:0] b, logic [15:0] im,
      logic [2:0] o, logic [2:0] s, logic w, logic [31:0] cr, logic so,
      string tag);
    @(negedge clk);
    rst = 1'b0; op_a = a; op_b = b; imm = im; op = o;
    field_sel = s; wide = w; cr_in = cr; so_in = so;
    sbq.push_back('{exp: model(a, b, im, o, s, w, cr, so), tag: tag});
  endtask

  task automatic drive_reset(string tag);
    @(negedge clk);
    rst = 1'b1;
    sbq.push_back('{exp: 32'h0, tag: tag});
  endtask

  task automatic check(logic [31:0] got, logic [31:0] exp, string tag);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Monitor: one expected item per captured edge.
  initial begin
    sb_item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check(cr_out, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R10: reset holds the output at zero whatever the inputs are.
    cr_in = 32'hDEAD_BEEF; op_a = 64'h5; op_b = 64'h7; so_in = 1'b1;
    repeat (3) @(posedge clk);
    #1 check(cr_out, 32'h0, "R10 reset state");

    // R3: narrow compare ignores the upper words.
    drive(64'hFFFFFFFF_AAAAAAAA, 64'h00000000_AAAAAAAA, 16'h0, 3'd0, 3'd2, 1'b0,
          32'h0, 1'b0, "R3 narrow equal");
    // R4/R5: wide signed ordering both ways.
    drive(64'hFFFFFFFF_AAAAAAAA, 64'h00000000_AAAAAAAA, 16'h0, 3'd0, 3'd2, 1'b1,
          32'h0, 1'b0, "R4 wide signed lt");
    drive(64'h00000000_AAAAAAAA, 64'hFFFFFFFF_AAAAAAAA, 16'h0, 3'd0, 3'd2, 1'b1,
          32'h0, 1'b0, "R4 wide signed gt");
    // R6: unsigned with SO.
    drive(64'h0, 64'hFFFF6DC1, 16'h0, 3'd1, 3'd1, 1'b0,
          32'h5075_9999, 1'b1, "R6 unsigned lt with so");
    drive(64'hFFFFFFFF_AAAAAAAA, 64'h00000000_AAAAAAAA, 16'h0, 3'd1, 3'd6, 1'b1,
          32'h1234_5678, 1'b0, "R6 wide unsigned gt");
    // R3/R5/R6: narrow sign bit decides signed vs unsigned.
    drive(64'h1_80000000, 64'h1, 16'h0, 3'd0, 3'd0, 1'b0,
          32'h0, 1'b0, "R5 narrow signed lt");
    drive(64'h1_80000000, 64'h1, 16'h0, 3'd1, 3'd0, 1'b0,
          32'h0, 1'b0, "R6 narrow unsigned gt");
    // R7: immediates.
    drive(64'h301FC7A7, 64'hFFFF, 16'd31132, 3'd3, 3'd5, 1'b0,
          32'h9021_5393, 1'b1, "R7 unsigned imm gt");
    drive(64'h0, 64'h0, 16'h8000, 3'd2, 3'd3, 1'b1,
          32'h0, 1'b0, "R7 signed imm gt");
    drive(64'h0, 64'h0, 16'h8000, 3'd3, 3'd3, 1'b1,
          32'h0, 1'b0, "R7 unsigned imm lt");
    drive(64'hFFFFFFFF_FFFF8000, 64'h0, 16'h8000, 3'd2, 3'd4, 1'b1,
          32'h0, 1'b0, "R7 signed imm equal");
    // R8: byte search over values 0..19 and every lane.
    for (int i = 0; i < 20; i++)
      drive(64'(i), 64'h0001030507090B0F, 16'h0, 3'd4, 3'd1, 1'b1,
            32'hFFFF_FFFF, 1'b1, "R8 byte search");
    for (int l = 0; l < 8; l++)
      drive(64'hFFFFFFFF_FFFFFFAB, 64'hAB << (8*l), 16'h0, 3'd4, 3'(l), 1'b0,
            32'h0, 1'b1, "R8 byte lane hit");
    // R2: each field position with a busy background.
    for (int s = 0; s < 8; s++)
      drive(64'h5, 64'h5, 16'h0, 3'd0, 3'(s), 1'b1,
            32'hA5C3_96F0, 1'b1, "R2 field position");
    // R9: reserved codes change nothing.
    for (int o = 5; o < 8; o++)
      drive(64'h1, 64'h2, 16'h3, 3'(o), 3'd0, 1'b1,
            32'h1357_9BDF, 1'b1, "R9 reserved op");
    // R10: reset in the middle of traffic.
    drive_reset("R10 mid-run reset");
    drive(64'h2, 64'h1, 16'h0, 3'd1, 3'd7, 1'b1,
          32'h0, 1'b0, "R10 after reset");
    // R1: random operands over every code.
    for (int n = 0; n < 300; n++) begin
      logic [63:0] ra, rb;
      ra = {$urandom, $urandom};
      rb = (n % 3 == 0) ? ra : {$urandom, $urandom};
      if (n % 5 == 0) rb[31:0] = ra[31:0];
      drive(ra, rb, 16'($urandom), 3'($urandom), 3'($urandom), 1'($urandom),
            $urandom, 1'($urandom), "R1 random");
    end

    repeat (3) @(posedge clk);
    #2;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule